// File: doc/BRIEF.md
# Message-Framed Asynchronous Serial Transmitter

This block is one transmit channel of a serial port. It pulls bytes from an external show-ahead transmit FIFO and puts them on a single line as asynchronous characters. Each character has a start bit, eight data bits, an optional parity bit and one or two stop bits. A bit-enable tick from an external baud generator paces every bit.

Bytes are grouped into messages. Software arms a start latch with a strobe. A message then begins as soon as the FIFO holds data. It ends after a programmed number of bytes, or, when that count is zero, once the FIFO runs dry. At completion the start latch can clear itself, or it can stay armed so that the next message follows automatically.

Two sticky interrupt flags report completion and a low FIFO level. A master enable gates both flags onto the outputs. A status output shows whether the message state machine is enabled.

Top module: `msg_uart_tx`

## Requirements
- R1: The line idles high. A character is a low start bit, then the eight data bits least significant bit first, then high stop bits. Each bit starts on a `baud_tick` cycle and holds until the next tick. Back-to-back characters follow one another with no extra idle bit.
- R2: With `cfg_par_en`=1 exactly one parity bit follows the eighth data bit. With `cfg_par_en`=0 the stop bits follow the data directly.
- R3: With `cfg_par_fixed`=0 the parity bit is computed. `cfg_par_sel`=1 makes the count of ones over data and parity odd, and `cfg_par_sel`=0 makes it even. With `cfg_par_fixed`=1 the parity bit equals `cfg_par_sel`.
- R4: `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two.
- R5: With a nonzero `byte_count` sampled at message start, the message completes after exactly that many bytes. Any further bytes stay in the FIFO.
- R6: With `byte_count`=0 the message completes when the FIFO level is zero after the last character.
- R7: A message starts only when the start latch is set and the FIFO is non-empty. A completion event never occurs for a message that sent no byte, and no read is issued from an empty FIFO.
- R8: When `cfg_done_ie`=1, completion sets the done flag. The flag holds until `irq_clr[0]` is pulsed. When `cfg_done_ie`=0, completion leaves the flag clear.
- R9: While `cfg_ae_ie`=1 and `fifo_level` <= `ae_thresh`, the almost-empty flag is set. Pulsing `irq_clr[1]` clears it only when that condition no longer holds.
- R10: `irq_done` and `irq_ae` are the flags ANDed with `master_ie`.
- R11: With `cfg_start_autoclr`=1 the start latch clears at completion. With it at 0 the latch stays set, and a new message starts when the FIFO is non-empty, with the byte count reloaded.
- R12: `tx_active` is 1 while the state machine is enabled. It is 0 after reset. Dropping `tx_en` clears the start latch at once. The machine then finishes the character in progress, stops reading the FIFO and drops `tx_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_sel | input | 1 | Odd parity select, or the fixed level in fixed mode |
| cfg_par_fixed | input | 1 | Parity bit takes a fixed level |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_start_autoclr | input | 1 | Clear the start latch on completion |
| cfg_done_ie | input | 1 | Done interrupt enable |
| cfg_ae_ie | input | 1 | Almost-empty interrupt enable |
| master_ie | input | 1 | Master interrupt gate |
| start_strobe | input | 1 | One-cycle pulse that sets the start latch |
| byte_count | input | CNT_W | Bytes per message (0 = until the FIFO is empty) |
| ae_thresh | input | LVL_W | Almost-empty threshold |
| irq_clr | input | 2 | Write-one-to-clear strobes: bit 0 done, bit 1 almost-empty |
| baud_tick | input | 1 | One-cycle bit-enable tick |
| fifo_data | input | 8 | Head word of the FIFO |
| fifo_level | input | LVL_W | FIFO fill level |
| fifo_rd | output | 1 | Pops the head word |
| ser_out | output | 1 | Serial line |
| tx_active | output | 1 | State machine enabled |
| irq_done | output | 1 | Message-done interrupt |
| irq_ae | output | 1 | FIFO almost-empty interrupt |

## Verification
The assertions assume that `fifo_data` is valid whenever `fifo_level` is nonzero, and that the level falls by exactly one on the edge after a `fifo_rd` pulse. They also assume that the format inputs hold steady while a character is on the line. The bench keeps to this. Its FIFO model pops on the same edge as the read, and it changes format, count and enables only after the scoreboard has drained and the line has gone quiet. The ticks come from a fixed divider, so the serial monitor can sample one bit per tick.

// File: rtl/msg_tx_pkg.sv
package msg_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    M_OFF  = 2'd0,
    M_IDLE = 2'd1,
    M_MSG  = 2'd2
  } msg_state_t;

  typedef struct packed {
    logic par_en;
    logic par_sel;
    logic par_fixed;
    logic two_stop;
  } tx_fmt_t;

  // parity bit for a data byte under a given format
  function automatic logic calc_parity(input logic [DATA_W-1:0] d, input tx_fmt_t f);
    if (f.par_fixed) return f.par_sel;
    return (^d) ^ f.par_sel;
  endfunction

  // whole character, bit 0 goes out first; unused high bits act as stops
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d, input tx_fmt_t f);
    logic [FRAME_W-1:0] w;
    w = '1;
    w[0] = 1'b0;
    w[DATA_W:1] = d;
    if (f.par_en) w[DATA_W+1] = calc_parity(d, f);
    return w;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input tx_fmt_t f);
    return LEN_W'(DATA_W + 2) + LEN_W'(f.par_en) + LEN_W'(f.two_stop);
  endfunction

endpackage

// File: rtl/tx_char_shifter.sv
module tx_char_shifter
  import msg_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  tx_fmt_t           fmt,
  output logic              ser_out,
  output logic              busy,
  output logic              char_end
);

  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   bits_left;

  // last bit leaves the register on this tick; the line stays high afterwards
  assign char_end = busy && baud_tick && (bits_left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      busy      <= 1'b0;
      ser_out   <= 1'b1;
    end else if (load) begin
      shreg     <= build_frame(data, fmt);
      bits_left <= frame_len(fmt);
      busy      <= 1'b1;
    end else if (busy && baud_tick) begin
      ser_out   <= shreg[0];
      shreg     <= {1'b1, shreg[FRAME_W-1:1]};
      bits_left <= bits_left - LEN_W'(1);
      if (char_end) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_msg_ctrl.sv
module tx_msg_ctrl
  import msg_tx_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             start_strobe,
  input  logic             autoclr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             sh_busy,
  output logic             load,
  output logic             done_evt,
  output logic             tx_active,
  output logic             start_latch
);

  msg_state_t       state, nstate;
  logic [CNT_W-1:0] remain;
  logic             counted;
  logic             fifo_has;
  logic             msg_end;

  assign fifo_has  = (fifo_level != '0);
  assign tx_active = (state != M_OFF);
  assign msg_end   = counted ? (remain == '0) : !fifo_has;

  always_comb begin
    nstate   = state;
    load     = 1'b0;
    done_evt = 1'b0;
    case (state)
      M_OFF: if (tx_en) nstate = M_IDLE;
      M_IDLE: begin
        if (!tx_en) nstate = M_OFF;
        else if (start_latch && fifo_has && !sh_busy) begin
          load   = 1'b1;
          nstate = M_MSG;
        end
      end
      M_MSG: begin
        if (!sh_busy) begin
          if (msg_end) begin
            done_evt = 1'b1;
            nstate   = tx_en ? M_IDLE : M_OFF;
          end else if (!tx_en) begin
            nstate = M_OFF;
          end else if (fifo_has) begin
            load = 1'b1;
          end
        end
      end
      default: nstate = M_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= M_OFF;
      remain  <= '0;
      counted <= 1'b0;
    end else begin
      state <= nstate;
      if (load && state == M_IDLE) begin
        counted <= (byte_count != '0);
        remain  <= byte_count - CNT_W'(1);
      end else if (load) begin
        remain  <= remain - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en)              start_latch <= 1'b0;
    else if (start_strobe)             start_latch <= 1'b1;
    else if (done_evt && autoclr)      start_latch <= 1'b0;
  end

endmodule

// File: rtl/tx_irq_unit.sv
module tx_irq_unit #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  logic             done_ie,
  input  logic             ae_ie,
  input  logic             master_ie,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] ae_thresh,
  input  logic [1:0]       clr,
  output logic             done_flag,
  output logic             ae_flag,
  output logic             irq_done,
  output logic             irq_ae
);

  function automatic logic at_low_mark(input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] thr);
    return lvl <= thr;
  endfunction

  logic ae_cond;
  assign ae_cond = ae_ie && at_low_mark(fifo_level, ae_thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      ae_flag   <= 1'b0;
    end else begin
      if (done_evt && done_ie) done_flag <= 1'b1;
      else if (clr[0])         done_flag <= 1'b0;
      if (ae_cond)             ae_flag   <= 1'b1;
      else if (clr[1])         ae_flag   <= 1'b0;
    end
  end

  assign irq_done = done_flag && master_ie;
  assign irq_ae   = ae_flag && master_ie;

endmodule

// File: rtl/msg_uart_tx.sv
module msg_uart_tx
  import msg_tx_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LVL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              cfg_par_en,
  input  logic              cfg_par_sel,
  input  logic              cfg_par_fixed,
  input  logic              cfg_two_stop,
  input  logic              cfg_start_autoclr,
  input  logic              cfg_done_ie,
  input  logic              cfg_ae_ie,
  input  logic              master_ie,
  input  logic              start_strobe,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [LVL_W-1:0]  ae_thresh,
  input  logic [1:0]        irq_clr,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_rd,
  output logic              ser_out,
  output logic              tx_active,
  output logic              irq_done,
  output logic              irq_ae
);

  tx_fmt_t fmt;
  logic    sh_busy, char_end, done_evt, start_latch;
  logic    done_flag, ae_flag;

  assign fmt = '{par_en: cfg_par_en, par_sel: cfg_par_sel,
                 par_fixed: cfg_par_fixed, two_stop: cfg_two_stop};

  tx_msg_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .start_strobe(start_strobe),
    .autoclr(cfg_start_autoclr), .byte_count(byte_count), .fifo_level(fifo_level),
    .sh_busy(sh_busy), .load(fifo_rd), .done_evt(done_evt),
    .tx_active(tx_active), .start_latch(start_latch)
  );

  tx_char_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(fifo_rd),
    .data(fifo_data), .fmt(fmt), .ser_out(ser_out), .busy(sh_busy),
    .char_end(char_end)
  );

  tx_irq_unit #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .done_ie(cfg_done_ie),
    .ae_ie(cfg_ae_ie), .master_ie(master_ie), .fifo_level(fifo_level),
    .ae_thresh(ae_thresh), .clr(irq_clr), .done_flag(done_flag),
    .ae_flag(ae_flag), .irq_done(irq_done), .irq_ae(irq_ae)
  );

endmodule

// File: rtl/msg_uart_tx_chk.sv
module msg_uart_tx_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_rd,
  input logic [LVL_W-1:0] fifo_level,
  input logic             done_evt,
  input logic             sh_busy,
  input logic             ser_out,
  input logic             baud_tick,
  input logic             master_ie,
  input logic             irq_done,
  input logic             irq_ae,
  input logic             done_flag,
  input logic [1:0]       irq_clr,
  input logic             tx_active
);

  logic [15:0] reads_in_msg;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_active || done_evt) reads_in_msg <= '0;
    else if (fifo_rd && reads_in_msg != '1) reads_in_msg <= reads_in_msg + 16'd1;
  end

  AST_RD_NEEDS_DATA:   assert property (@(posedge clk) disable iff (!rst_n) fifo_rd |-> fifo_level != '0);            // R7
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) done_evt |-> reads_in_msg != '0);         // R7
  AST_IDLE_LINE_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) !sh_busy |-> ser_out);                    // R1
  AST_LINE_ON_TICK:    assert property (@(posedge clk) disable iff (!rst_n) !$past(baud_tick) |-> $stable(ser_out)); // R1
  AST_IRQ_MASKED:      assert property (@(posedge clk) disable iff (!rst_n) !master_ie |-> !irq_done && !irq_ae);     // R10
  AST_DONE_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) done_flag && !irq_clr[0] |=> done_flag);  // R8
  AST_OFF_NO_READ:     assert property (@(posedge clk) disable iff (!rst_n) !tx_active |-> !fifo_rd);                 // R12

endmodule

bind msg_uart_tx msg_uart_tx_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .fifo_level(fifo_level),
  .done_evt(done_evt), .sh_busy(sh_busy), .ser_out(ser_out), .baud_tick(baud_tick),
  .master_ie(master_ie), .irq_done(irq_done), .irq_ae(irq_ae),
  .done_flag(done_flag), .irq_clr(irq_clr), .tx_active(tx_active)
);

// File: tb/tb_msg_uart_tx.sv
`timescale 1ns/1ps
module tb_msg_uart_tx;

  localparam int CNT_W = 8;
  localparam int LVL_W = 7;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, cfg_par_en = 0, cfg_par_sel = 0, cfg_par_fixed = 0, cfg_two_stop = 0;
  logic cfg_start_autoclr = 1, cfg_done_ie = 1, cfg_ae_ie = 0, master_ie = 1, start_strobe = 0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [LVL_W-1:0] ae_thresh = '0;
  logic [1:0]       irq_clr = '0;
  logic             baud_tick = 1'b0;
  logic [7:0]       fifo_data;
  logic [LVL_W-1:0] fifo_level;
  logic fifo_rd, ser_out, tx_active, irq_done, irq_ae;

  always #4 clk = ~clk;  // 125 MHz

  // FIFO model (show-ahead)
  logic [7:0]       mem [0:63];
  logic [LVL_W-1:0] wp = '0, rp;
  assign fifo_level = wp - rp;
  assign fifo_data  = mem[rp[5:0]];
  always @(posedge clk) begin
    if (!rst_n) rp <= '0;
    else if (fifo_rd) rp <= rp + 1'b1;
  end

  int div_cnt = 0;
  always @(negedge clk) begin
    div_cnt   <= (div_cnt == DIV-1) ? 0 : div_cnt + 1;
    baud_tick <= (div_cnt == DIV-1);
  end

  msg_uart_tx #(.CNT_W(CNT_W), .LVL_W(LVL_W)) dut (.*);

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    mem[wp[5:0]] = b;
    wp = wp + 1'b1;
    exp_q.push_back(b);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_strobe = 1;
    @(negedge clk) start_strobe = 0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    @(negedge clk) irq_clr = m;
    @(negedge clk) irq_clr = '0;
  endtask

  task automatic settle();
    repeat (20 * DIV) @(negedge clk);
  endtask

  // monitor: decode the line and compare against the scoreboard
  task automatic wait_tick();
    logic tk;
    do begin
      @(posedge clk); tk = baud_tick;
      @(negedge clk);
    end while (!tk);
  endtask

  initial begin
    logic [7:0] b;
    logic pb, stop_ok, exp_p;
    forever begin
      wait_tick();
      if (rst_n && ser_out == 1'b0) begin
        for (int i = 0; i < 8; i++) begin wait_tick(); b[i] = ser_out; end
        pb = 1'b1;
        if (cfg_par_en) begin wait_tick(); pb = ser_out; end
        stop_ok = 1'b1;
        for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin wait_tick(); stop_ok &= ser_out; end
        chk(stop_ok, "R4 stop bits high", stop_ok, 1);
        if (exp_q.size() == 0) chk(0, "R1 unexpected character", b, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(b == e, "R1 data byte", b, e);
        end
        if (cfg_par_en) begin
          exp_p = cfg_par_fixed ? cfg_par_sel : ((^b) ^ cfg_par_sel);
          chk(pb == exp_p, cfg_par_fixed ? "R3 fixed parity" : "R2 R3 parity bit", pb, exp_p);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ser_out == 1 && !irq_done && !fifo_rd, "R1 reset idle", ser_out, 1);
    chk(tx_active == 0, "R12 reset status", tx_active, 0);

    tx_en = 1;
    repeat (2) @(negedge clk);
    chk(tx_active == 1, "R12 enabled status", tx_active, 1);

    // R7: data without start stays put
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h01);
    repeat (100) @(negedge clk);
    chk(fifo_level == 3, "R7 no start no send", fifo_level, 3);
    // R6 zero count, no parity, one stop
    pulse_start();
    wait (irq_done == 1); settle();
    chk(fifo_level == 0 && exp_q.size() == 0, "R6 drained message", fifo_level, 0);
    chk(irq_done == 1, "R8 done flag set", irq_done, 1);
    pulse_clr(2'b01);
    chk(irq_done == 0, "R8 done cleared", irq_done, 0);

    // R5 counted message with even parity
    byte_count = 2; cfg_par_en = 1; cfg_par_sel = 0;
    push_byte(8'h55); push_byte(8'h80); push_byte(8'hF0); push_byte(8'h0F);
    pulse_start();
    wait (irq_done == 1); settle();
    chk(fifo_level == 2, "R5 count stop", fifo_level, 2);
    repeat (200) @(negedge clk);
    chk(fifo_level == 2, "R11 latch self-cleared", fifo_level, 2);
    pulse_clr(2'b01);

    // odd parity, two stops
    byte_count = 0; cfg_par_sel = 1; cfg_two_stop = 1;
    pulse_start();
    wait (irq_done == 1); settle();
    chk(fifo_level == 0 && exp_q.size() == 0, "R4 R2 odd two-stop message", exp_q.size(), 0);
    pulse_clr(2'b01);

    // fixed parity levels
    cfg_two_stop = 0; cfg_par_fixed = 1; cfg_par_sel = 1;
    push_byte(8'h00); push_byte(8'h07);
    pulse_start(); wait (irq_done == 1); settle(); pulse_clr(2'b01);
    cfg_par_sel = 0;
    push_byte(8'hFF); push_byte(8'h12);
    pulse_start(); wait (irq_done == 1); settle(); pulse_clr(2'b01);
    chk(exp_q.size() == 0, "R3 fixed parity messages", exp_q.size(), 0);
    cfg_par_fixed = 0; cfg_par_en = 0;

    // R7 empty message never completes
    pulse_start();
    repeat (200) @(negedge clk);
    chk(irq_done == 0, "R7 no done for zero bytes", irq_done, 0);
    push_byte(8'h9A);
    wait (irq_done == 1); settle(); pulse_clr(2'b01);

    // R8 done_ie off
    cfg_done_ie = 0;
    push_byte(8'h44); pulse_start();
    repeat (20 * DIV) @(negedge clk); settle();
    chk(irq_done == 0 && exp_q.size() == 0, "R8 done_ie off", irq_done, 0);
    cfg_done_ie = 1;

    // R11 latch kept, count reloaded
    cfg_start_autoclr = 0; byte_count = 1;
    push_byte(8'h61); pulse_start();
    wait (irq_done == 1); settle(); pulse_clr(2'b01);
    push_byte(8'h62); push_byte(8'h63);
    wait (exp_q.size() == 0); settle();
    chk(fifo_level == 0 && irq_done == 1, "R11 rearmed messages", fifo_level, 0);
    pulse_clr(2'b01);

    // R12 disable mid-message
    byte_count = 0;
    push_byte(8'hC1); push_byte(8'hC2); push_byte(8'hC3);
    wait (fifo_level == 2);
    @(negedge clk) tx_en = 0;
    chk(tx_active == 1, "R12 finishing character", tx_active, 1);
    repeat (15 * DIV) @(negedge clk);
    chk(tx_active == 0 && fifo_level == 2, "R12 stopped after character", fifo_level, 2);
    tx_en = 1;
    repeat (200) @(negedge clk);
    chk(fifo_level == 2, "R12 latch cleared by disable", fifo_level, 2);
    cfg_start_autoclr = 1;
    pulse_start(); wait (exp_q.size() == 0); settle(); pulse_clr(2'b01);

    // R9/R10 almost-empty flag
    ae_thresh = 1; cfg_ae_ie = 1;
    repeat (2) @(negedge clk);
    chk(irq_ae == 1, "R9 level at or below mark", irq_ae, 1);
    pulse_clr(2'b10);
    chk(irq_ae == 1, "R9 clear ignored while low", irq_ae, 1);
    master_ie = 0; @(negedge clk);
    chk(irq_ae == 0, "R10 master gate", irq_ae, 0);
    master_ie = 1; @(negedge clk);
    chk(irq_ae == 1, "R10 master reopens", irq_ae, 1);
    push_byte(8'h10); push_byte(8'h20); push_byte(8'h30);
    pulse_clr(2'b10);
    chk(irq_ae == 0, "R9 cleared above mark", irq_ae, 0);
    pulse_start();
    wait (irq_done == 1); settle();
    chk(irq_ae == 1 && exp_q.size() == 0, "R9 set after draining", irq_ae, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule